// File: doc/BRIEF.md
# Serial Load/Store Address and Byte Formatter

This unit sits in the load/store path of a 16-bit bit-serial processor. Register bits, memory bits and store bits all arrive one bit per clock, least significant bit first. The unit handles three jobs.

- **Address phase.** It forms the memory address. The address is either the base operand alone or the serial sum of the base and a second operand. The sum can also be returned for write-back to the base register, which gives the post-increment and pre-increment forms.
- **Load phase.** It formats the 16 data bits read from memory into a halfword, a zero-extended byte or a sign-extended byte. At the end of the word it updates the N, Z and C flags.
- **Store phase.** It passes the store data through, replacing it with the written-back sum when the store register is also the base. For byte stores it gates the serial clock enable so that only the low byte reaches memory.

**Phase sequencing.** An outside sequencer drives `phase`. Each phase lasts exactly 16 accepted bits, and the sequencer holds `phase` at idle for at least one cycle between phases.

**Stream rules.** Every serial input carries the shared `in_vld` qualifier. Each serial output is valid in the same cycle as the input bit it answers. The unit has no internal buffering and accepts a bit on every cycle that `in_vld` is high, so there is no ready signal and no back-pressure. Stalling is done by lowering `in_vld`.

**Access kind.** `acc_kind` carries the low three bits of the major opcode (0x8 to 0xB are loads, 0xC to 0xF are stores).
- Bit 2 selects a store.
- Bit 1 selects write-back.
- Bit 0 selects the sum as the address.
- Kind 00 in bits 1:0 is the byte access.

Top module: `lsu_serial_top`

## Requirements
- R1: During the address phase, `addr_bit` equals `a_bit` when `acc_kind[0]`=0. When `acc_kind[0]`=1 it is the carry-propagating serial sum a+b, LSB first, modulo 2^16.
- R2: `wb_vld` is high for every accepted address bit when `acc_kind[1]`=1, and is never high otherwise. `wb_bit` carries the serial sum a+b.
- R3: A byte access (`acc_kind[1:0]`=00) ignores `b_bit`. Its address is `a_bit` whatever the second operand holds.
- R4: A halfword load (`acc_kind[1:0]`≠00) returns all 16 memory bits unchanged on `ld_bit`, with `ld_vld` high for each bit.
- R5: A byte load passes memory bits 0..7 through. Bits 8..15 copy memory bit 7 when `minor`=1 and are 0 for every other `minor` value.
- R6: At the end of a load, C becomes memory bit 7 and N becomes memory bit 15. Z becomes 1 exactly when all 16 formatted result bits are 0.
- R7: Address and store phases, and idle cycles, leave `flag_n`, `flag_z` and `flag_c` unchanged.
- R8: A byte store holds `sck_en` high for bits 0..7 and low for bits 8..15. A halfword store holds it high for all 16 bits. `sdo_bit` carries all 16 store bits in both cases.
- R9: When `st_same_reg`=1 and the store kind writes back (`acc_kind[1]`=1), `sdo_bit` sends the value written back in the preceding address phase. Otherwise `sdo_bit` follows `st_bit`.
- R10: While reset is held, the flags are 0, and `sck_en`, `wb_vld` and `ld_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase | input | 2 | 0 idle, 1 address, 2 load, 3 store |
| acc_kind | input | 3 | Store select, write-back select, sum-address select |
| minor | input | 3 | Byte load extension: 1 sign-extends, other values zero-extend |
| st_same_reg | input | 1 | Store data register equals the base register |
| in_vld | input | 1 | Serial input bit valid |
| a_bit | input | 1 | Base operand bit |
| b_bit | input | 1 | Second operand bit |
| mem_bit | input | 1 | Load data bit from memory |
| st_bit | input | 1 | Store data bit from the register file |
| addr_bit | output | 1 | Address bit to the address register |
| wb_bit | output | 1 | Write-back bit for the base register |
| wb_vld | output | 1 | Write-back bit valid |
| ld_bit | output | 1 | Formatted load bit |
| ld_vld | output | 1 | Load bit valid |
| sdo_bit | output | 1 | Serial store data out |
| sck_en | output | 1 | Serial clock enable for the current bit |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The address phase is driven for all four capture and write-back kinds. The operand pairs include corner values such as 0xFFFF+1, which carries through every bit, and a nonzero second operand on the byte kind, which separates sum-addressing from first-operand addressing.

Loads cover each kind with `minor` set to 0, 1 and 5. The data patterns put bit 7 and bit 15 at opposite values, so sign extension, zero extension and the N and C sources are told apart. An all-zero-low-byte pattern with a set top byte shows that Z looks at the formatted result.

Stores cover byte and halfword clock gating. They also run each write-back and no-write-back kind with `st_same_reg` set, which separates substitution from pass-through. A load followed by store and address phases shows that the flags persist.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_LOAD  = 2'd2,
    PH_STORE = 2'd3
  } phase_e;

  typedef struct packed {
    logic is_store;
    logic wb;
    logic use_sum;
  } acc_t;

  function automatic acc_t acc_decode(input logic [2:0] k);
    acc_t r;
    r.is_store = k[2];
    r.wb       = k[1];
    r.use_sum  = k[0];
    return r;
  endfunction

  // byte access: no sum capture and no write-back
  function automatic logic acc_is_byte(input acc_t a);
    return !a.wb && !a.use_sum;
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic vld,
  input  acc_t acc,
  input  logic a_bit,
  input  logic b_bit,
  input  logic hold_rot,
  output logic addr_bit,
  output logic wb_bit,
  output logic wb_vld,
  output logic hold_bit
);
  logic             cy;
  logic             b_eff;
  logic             sum;
  logic             cout;
  logic [WIDTH-1:0] hold;
  logic             take;

  assign b_eff = acc_is_byte(acc) ? 1'b0 : b_bit;
  assign sum   = a_bit ^ b_eff ^ cy;
  assign cout  = (a_bit & b_eff) | (a_bit & cy) | (b_eff & cy);
  assign take  = active && vld;

  assign addr_bit = acc.use_sum ? sum : a_bit;
  assign wb_bit   = sum;
  assign wb_vld   = take && acc.wb;
  assign hold_bit = hold[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy <= 1'b0;
    end else if (restart) begin
      cy <= 1'b0;
    end else if (take) begin
      cy <= cout;
    end
  end

  // keeps the written-back value so a store of the same register sees it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (take && acc.wb) begin
      hold <= {sum, hold[WIDTH-1:1]};
    end else if (hold_rot) begin
      hold <= {hold[0], hold[WIDTH-1:1]};
    end
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt #(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8,
  localparam int CW    = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          vld,
  input  logic [CW-1:0] idx,
  input  logic          mem_bit,
  input  logic          byte_mode,
  input  logic          sext,
  output logic          ld_bit,
  output logic          ld_vld,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c
);
  localparam logic [CW-1:0] SGN_IDX  = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] HI_START = CW'(BYTE_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic sgn;
  logic zacc;
  logic upper;
  logic take;

  assign take   = active && vld;
  assign upper  = idx >= HI_START;
  assign ld_bit = (byte_mode && upper) ? (sext & sgn) : mem_bit;
  assign ld_vld = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn  <= 1'b0;
      zacc <= 1'b0;
    end else if (take) begin
      if (idx == SGN_IDX) sgn <= mem_bit;
      zacc <= (idx == '0) ? ld_bit : (zacc | ld_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (take && idx == LAST_IDX) begin
      flag_n <= mem_bit;
      flag_z <= ~(zacc | ld_bit);
      flag_c <= sgn;
    end
  end
endmodule

// File: rtl/lsu_store_gate.sv
module lsu_store_gate #(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8,
  localparam int CW    = $clog2(WIDTH)
) (
  input  logic          active,
  input  logic          vld,
  input  logic [CW-1:0] idx,
  input  logic          byte_mode,
  input  logic          subst,
  input  logic          st_bit,
  input  logic          hold_bit,
  output logic          sdo_bit,
  output logic          sck_en
);
  localparam logic [CW-1:0] HI_START = CW'(BYTE_W);

  assign sck_en  = active && vld && !(byte_mode && idx >= HI_START);
  assign sdo_bit = subst ? hold_bit : st_bit;
endmodule

// File: rtl/lsu_serial_top.sv
module lsu_serial_top
  import lsu_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase,
  input  logic [2:0] acc_kind,
  input  logic [2:0] minor,
  input  logic       st_same_reg,
  input  logic       in_vld,
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       mem_bit,
  input  logic       st_bit,
  output logic       addr_bit,
  output logic       wb_bit,
  output logic       wb_vld,
  output logic       ld_bit,
  output logic       ld_vld,
  output logic       sdo_bit,
  output logic       sck_en,
  output logic       flag_n,
  output logic       flag_z,
  output logic       flag_c
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  phase_e        ph;
  acc_t          acc;
  logic [CW-1:0] idx;
  logic          byte_mode;
  logic          st_act;
  logic          hold_bit;
  logic          subst;

  assign ph        = phase_e'(phase);
  assign acc       = acc_decode(acc_kind);
  assign byte_mode = acc_is_byte(acc);
  assign st_act    = ph == PH_STORE;
  assign subst     = st_same_reg && acc.wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (ph == PH_IDLE) begin
      idx <= '0;
    end else if (in_vld) begin
      idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end
  end

  lsu_addr_gen #(.WIDTH(WIDTH)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ph == PH_IDLE),
    .active   (ph == PH_ADDR),
    .vld      (in_vld),
    .acc      (acc),
    .a_bit    (a_bit),
    .b_bit    (b_bit),
    .hold_rot (st_act && in_vld && subst),
    .addr_bit (addr_bit),
    .wb_bit   (wb_bit),
    .wb_vld   (wb_vld),
    .hold_bit (hold_bit)
  );

  lsu_load_fmt #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (ph == PH_LOAD),
    .vld       (in_vld),
    .idx       (idx),
    .mem_bit   (mem_bit),
    .byte_mode (byte_mode),
    .sext      (minor == 3'd1),
    .ld_bit    (ld_bit),
    .ld_vld    (ld_vld),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c)
  );

  lsu_store_gate #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_store (
    .active    (st_act),
    .vld       (in_vld),
    .idx       (idx),
    .byte_mode (byte_mode),
    .subst     (subst),
    .st_bit    (st_bit),
    .hold_bit  (hold_bit),
    .sdo_bit   (sdo_bit),
    .sck_en    (sck_en)
  );
endmodule

// File: rtl/lsu_serial_chk.sv
module lsu_serial_chk #(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic [2:0] acc_kind,
  input logic [2:0] minor,
  input logic       in_vld,
  input logic       wb_vld,
  input logic       ld_bit,
  input logic       sck_en,
  input logic       flag_n,
  input logic       flag_z,
  input logic       flag_c
);
  localparam int CW = $clog2(WIDTH);

  logic [CW-1:0] cnt;
  logic          hi_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (phase == 2'd0) cnt <= '0;
    else if (in_vld) cnt <= (cnt == CW'(WIDTH - 1)) ? '0 : cnt + 1'b1;
  end

  assign hi_half = cnt >= CW'(BYTE_W);

  // R8
  byte_store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && in_vld && acc_kind[1:0] == 2'b00 && hi_half) |-> !sck_en);

  // R8
  half_store_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && in_vld && acc_kind[1:0] != 2'b00) |-> sck_en);

  // R2
  wb_only_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |-> (phase == 2'd1 && acc_kind[1]));

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd2) |=> $stable({flag_n, flag_z, flag_c}));

  // R5
  zext_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && in_vld && acc_kind[1:0] == 2'b00 && minor != 3'd1 && hi_half)
      |-> !ld_bit);
endmodule

bind lsu_serial_top lsu_serial_chk #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase),
  .acc_kind (acc_kind),
  .minor    (minor),
  .in_vld   (in_vld),
  .wb_vld   (wb_vld),
  .ld_bit   (ld_bit),
  .sck_en   (sck_en),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_c   (flag_c)
);

// File: tb/sim_lsu_serial_top.sv
module sim_lsu_serial_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] phase = 2'd0;
  logic [2:0] acc_kind = 3'd0;
  logic [2:0] minor = 3'd0;
  logic       st_same_reg = 1'b0;
  logic       in_vld = 1'b0;
  logic       a_bit = 1'b0, b_bit = 1'b0, mem_bit = 1'b0, st_bit = 1'b0;
  logic       addr_bit, wb_bit, wb_vld, ld_bit, ld_vld, sdo_bit, sck_en;
  logic       flag_n, flag_z, flag_c;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lsu_serial_top u0 (
    .clk(clk), .rst_n(rst_n), .phase(phase), .acc_kind(acc_kind), .minor(minor),
    .st_same_reg(st_same_reg), .in_vld(in_vld), .a_bit(a_bit), .b_bit(b_bit),
    .mem_bit(mem_bit), .st_bit(st_bit), .addr_bit(addr_bit), .wb_bit(wb_bit),
    .wb_vld(wb_vld), .ld_bit(ld_bit), .ld_vld(ld_vld), .sdo_bit(sdo_bit),
    .sck_en(sck_en), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic end_phase();
    @(negedge clk);
    phase  = 2'd0;
    in_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_addr(input logic [2:0] k, input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] ad, output logic [15:0] wb, output logic [15:0] wm);
    acc_kind = k;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      phase = 2'd1; in_vld = 1'b1; a_bit = a[i]; b_bit = b[i];
      #1;
      ad[i] = addr_bit; wb[i] = wb_bit; wm[i] = wb_vld;
    end
    end_phase();
  endtask

  task automatic do_load(input logic [2:0] k, input logic [2:0] mn, input logic [15:0] m,
                         output logic [15:0] res, output logic [15:0] vm);
    acc_kind = k; minor = mn;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      phase = 2'd2; in_vld = 1'b1; mem_bit = m[i];
      #1;
      res[i] = ld_bit; vm[i] = ld_vld;
    end
    end_phase();
  endtask

  task automatic do_store(input logic [2:0] k, input logic same, input logic [15:0] s,
                          output logic [15:0] sd, output logic [15:0] ck);
    acc_kind = k; st_same_reg = same;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      phase = 2'd3; in_vld = 1'b1; st_bit = s[i];
      #1;
      sd[i] = sdo_bit; ck[i] = sck_en;
    end
    end_phase();
    st_same_reg = 1'b0;
  endtask

  function automatic logic [15:0] pick(input int j);
    logic [15:0] corner [6];
    corner[0] = 16'h0000; corner[1] = 16'hFFFF; corner[2] = 16'h8000;
    corner[3] = 16'h007F; corner[4] = 16'h0080; corner[5] = 16'hFF00;
    if (j < 6) return corner[j];
    return 16'(j * 40503 + 12345);
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ad, wb, wm, res, vm, sd, ck, ex, a, b;
    logic [2:0] fl;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 flags", {13'd0, flag_n, flag_z, flag_c}, 16'd0);
    check("R10 strobes", {13'd0, sck_en, wb_vld, ld_vld}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 address sweep over kinds and operands
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 10; j++) begin
        a = pick(j);
        b = (j == 0) ? 16'h0001 : pick(j + 3) ^ 16'h5A5A;
        if (j == 1) b = 16'h0001;
        do_addr(3'(k), a, b, ad, wb, wm);
        ex = (k[0]) ? a + b : a;
        check(k == 0 ? "R3 byte address ignores b" : "R1 address", ad, ex);
        check("R2 write-back valid", wm, k[1] ? 16'hFFFF : 16'h0000);
        if (k[1]) check("R2 write-back value", wb, a + b);
      end
    end

    // R4 R5 R6 load sweep
    for (int k = 0; k < 4; k++) begin
      for (int mi = 0; mi < 3; mi++) begin
        for (int j = 0; j < 9; j++) begin
          logic [2:0] mn;
          logic [15:0] m;
          mn = (mi == 0) ? 3'd0 : (mi == 1) ? 3'd1 : 3'd5;
          m = pick(j) ^ ((j == 8) ? 16'h0000 : 16'h0000);
          if (j == 6) m = 16'h7F80;
          if (j == 7) m = 16'h807F;
          do_load(3'(k), mn, m, res, vm);
          if (k == 0) ex = (mn == 3'd1) ? {{8{m[7]}}, m[7:0]} : {8'h00, m[7:0]};
          else        ex = m;
          check(k == 0 ? "R5 byte load format" : "R4 halfword load", res, ex);
          check("R4 load valid", vm, 16'hFFFF);
          check("R6 flags", {13'd0, flag_n, flag_z, flag_c},
                {13'd0, m[15], (ex == 16'h0000), m[7]});
        end
      end
    end

    // R7 flags survive store and address phases
    do_load(3'd1, 3'd0, 16'h8080, res, vm);
    fl = {flag_n, flag_z, flag_c};
    do_store(3'd5, 1'b0, 16'h0000, sd, ck);
    do_addr(3'd3, 16'h0000, 16'h0000, ad, wb, wm);
    repeat (3) @(negedge clk);
    check("R7 flags unchanged", {13'd0, flag_n, flag_z, flag_c}, {13'd0, fl});

    // R8 store clock gating and pass-through
    for (int k = 4; k < 8; k++) begin
      for (int j = 0; j < 6; j++) begin
        logic [15:0] s;
        s = pick(j + 4);
        do_store(3'(k), 1'b0, s, sd, ck);
        check("R8 sck enable", ck, (k[1:0] == 2'b00) ? 16'h00FF : 16'hFFFF);
        check("R8 store data", sd, s);
      end
    end

    // R9 written-back value substitution
    for (int k = 4; k < 8; k++) begin
      for (int j = 0; j < 4; j++) begin
        logic [15:0] s;
        a = pick(j + 1);
        b = pick(j + 7);
        s = 16'hC3A5 ^ 16'(j);
        do_addr(3'(k), a, b, ad, wb, wm);
        do_store(3'(k), 1'b1, s, sd, ck);
        check("R9 store source", sd, k[1] ? a + b : s);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule